// File: doc/BRIEF.md
# Credit Priority VM Scheduler

This block decides which of `NUM_VM` virtual machines owns the processor next. Each VM has a signed credit balance. A periodic tick takes `TICK_COST` from the VM that is running. A VM waiting to run sits in one of three priority classes. BOOST is the highest class and holds VMs that were woken by an I/O event. UNDER holds VMs with positive credit. OVER holds VMs whose credit is zero or negative. Within a class, VMs are served in the order in which they became ready.

A runner gives up the processor in four cases: it finishes a slice of `SLICE_TICKS` ticks, it asks to switch, it stops being runnable, or a boosted VM preempts it. In the first three cases it gives up the processor in the same way. If it is still runnable, it goes back to the tail of its class and loses any boost. When the sum of all balances drops below zero, every balance is reloaded from the programmable allotment inputs. The outputs are the index of the current runner, a valid flag and a one-cycle preempt strobe. The external context switch acts on these outputs.

Top module: `vm_credit_sched`

## Requirements
- R1: While reset is asserted and in the cycle after release, `run_valid_o` and `preempt_o` are low.
- R2: On each clock edge with `tick_i` high and a runner present, the runner's credit falls by `TICK_COST`. A waiting VM ranks UNDER when its credit is above zero and OVER otherwise.
- R3: When several VMs wait, the pick follows class priority BOOST > UNDER > OVER. An OVER VM is picked only if no UNDER or BOOST VM waits.
- R4: Within one class, the VM that entered the queue earliest is picked first. VMs that enter in the same cycle are ordered with the lower index first. A VM enters the queue when it is idle and `runnable_i` is high, or when it leaves the processor while still runnable.
- R5: A runner keeps its index on `run_vm_o` until it leaves. At the edge of its `SLICE_TICKS`-th tick it leaves, and `run_valid_o` is low for exactly one cycle when another VM waits. The pick happens at the first edge with no runner and at least one waiting VM.
- R6: `yield_i` high at an edge with a runner present switches the runner out. It is requeued at the tail if it is still runnable.
- R7: In the first cycle after reset, and in any cycle where the sum of all credits is negative, every credit is loaded from `allot_i` bits `[i*CRED_W +: CRED_W]` (signed). That cycle's tick debit is dropped.
- R8: A VM woken with `io_evt_i` high enters BOOST. It keeps the boost while it runs and loses it when it leaves the processor or the queue.
- R9: If a boosted VM waits and the runner is not boosted, and the runner is not leaving for another reason, the runner is switched out. `preempt_o` is high for one cycle, the same cycle in which `run_valid_o` is low. A boosted runner is never preempted.
- R10: A runner whose `runnable_i` bit is low leaves without requeue. A waiting VM whose bit is low leaves the queue. An I/O event on an idle VM that is not runnable has no effect.
- R11: While no VM is runnable, `run_valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Periodic debit tick, one cycle wide |
| runnable_i | input | NUM_VM | Per-VM runnable level |
| io_evt_i | input | NUM_VM | Per-VM I/O event, marks a wake as boosted |
| yield_i | input | 1 | Switch request from the current runner |
| allot_i | input | NUM_VM*CRED_W | Signed per-VM credit allotment |
| run_vm_o | output | IDX_W | Index of the current runner |
| run_valid_o | output | 1 | A runner is selected |
| preempt_o | output | 1 | One-cycle strobe: runner displaced by a boosted VM |

## Verification
The selection logic is driven with several patterns, and each one isolates one ordering rule:
- Simultaneous wakes with frequent switch requests and no ticks expose the FIFO order and the lower-index tie rule.
- Back-to-back ticks with small or negative allotments push VMs into OVER and force repeated reloads, which separates class priority from queue age.
- Sparse wakes with I/O events, including one against a non-boosted runner, test the preemption path against the boosted-runner exemption.
- Frequent runnable drops test the leave-without-requeue rule.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
   // Ordering matters: a larger code wins the pick.
   typedef enum logic [1:0] {
      CLS_OVER  = 2'd0,
      CLS_UNDER = 2'd1,
      CLS_BOOST = 2'd2
   } vm_class_e;
endpackage

// File: rtl/vcs_credit_bank.sv
module vcs_credit_bank #(
   parameter int NUM_VM    = 4,
   parameter int CRED_W    = 16,
   parameter int TICK_COST = 10,
   parameter int IDX_W     = 2
)(
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [NUM_VM*CRED_W-1:0] allot_i,
   input  logic                     debit_en_i,
   input  logic [IDX_W-1:0]         debit_idx_i,
   output logic [NUM_VM-1:0]        under_o
);
   localparam int SUM_W = CRED_W + $clog2(NUM_VM) + 1;
   localparam logic [CRED_W-1:0] COST_C = CRED_W'(TICK_COST);

   logic [NUM_VM-1:0][CRED_W-1:0] credit_q;
   logic signed [SUM_W-1:0]       total;
   logic                          primed_q;
   logic                          reload;

   always_comb begin
      total = '0;
      for (int i = 0; i < NUM_VM; i++) begin
         total = total + $signed({{(SUM_W-CRED_W){credit_q[i][CRED_W-1]}}, credit_q[i]});
      end
   end

   assign reload = !primed_q || total[SUM_W-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         primed_q <= 1'b0;
         credit_q <= '0;
      end else begin
         primed_q <= 1'b1;
         for (int i = 0; i < NUM_VM; i++) begin
            if (reload) begin
               credit_q[i] <= allot_i[i*CRED_W +: CRED_W];
            end else if (debit_en_i && debit_idx_i == IDX_W'(i)) begin
               credit_q[i] <= credit_q[i] - COST_C;
            end
         end
      end
   end

   for (genvar g = 0; g < NUM_VM; g++) begin : g_cls
      assign under_o[g] = !credit_q[g][CRED_W-1] && (credit_q[g] != '0);
   end
endmodule

// File: rtl/vcs_age_pick.sv
module vcs_age_pick #(
   parameter int NUM_VM = 4,
   parameter int IDX_W  = 2
)(
   input  logic                               clk_i,
   input  logic                               rst_ni,
   input  logic [NUM_VM-1:0]                  enq_i,
   input  logic [NUM_VM-1:0]                  cand_i,
   input  vcs_pkg::vm_class_e [NUM_VM-1:0]    cls_i,
   output logic [NUM_VM-1:0]                  win_oh_o,
   output logic [IDX_W-1:0]                   win_idx_o,
   output logic                               any_o
);
   import vcs_pkg::*;

   // ahead_q[i][j] set: i entered the queue before j. Diagonal held at one.
   logic [NUM_VM-1:0][NUM_VM-1:0] ahead_q;
   logic [NUM_VM-1:0]             elig;
   vm_class_e                     best;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < NUM_VM; i++) begin
            for (int j = 0; j < NUM_VM; j++) begin
               ahead_q[i][j] <= (i == j);
            end
         end
      end else begin
         for (int i = 0; i < NUM_VM; i++) begin
            for (int j = 0; j < NUM_VM; j++) begin
               if (i != j) begin
                  if (enq_i[i] && enq_i[j])  ahead_q[i][j] <= (i < j);
                  else if (enq_i[i])         ahead_q[i][j] <= 1'b0;
                  else if (enq_i[j])         ahead_q[i][j] <= 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      best = CLS_OVER;
      for (int i = 0; i < NUM_VM; i++) begin
         if (cand_i[i] && cls_i[i] > best) best = cls_i[i];
      end
   end

   for (genvar g = 0; g < NUM_VM; g++) begin : g_win
      assign elig[g]     = cand_i[g] && (cls_i[g] == best);
      assign win_oh_o[g] = elig[g] && (&(ahead_q[g] | ~elig));
   end

   always_comb begin
      win_idx_o = '0;
      for (int i = 0; i < NUM_VM; i++) begin
         if (win_oh_o[i]) win_idx_o = win_idx_o | IDX_W'(i);
      end
   end

   assign any_o = |cand_i;
endmodule

// File: rtl/vm_credit_sched.sv
module vm_credit_sched #(
   parameter int NUM_VM      = 4,
   parameter int CRED_W      = 16,
   parameter int TICK_COST   = 10,
   parameter int SLICE_TICKS = 3,
   localparam int IDX_W      = (NUM_VM > 1) ? $clog2(NUM_VM) : 1
)(
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     tick_i,
   input  logic [NUM_VM-1:0]        runnable_i,
   input  logic [NUM_VM-1:0]        io_evt_i,
   input  logic                     yield_i,
   input  logic [NUM_VM*CRED_W-1:0] allot_i,
   output logic [IDX_W-1:0]         run_vm_o,
   output logic                     run_valid_o,
   output logic                     preempt_o
);
   import vcs_pkg::*;

   localparam int SLC_W = $clog2(SLICE_TICKS + 1);
   localparam logic [SLC_W-1:0] SLC_LAST = SLC_W'(SLICE_TICKS - 1);

   if (NUM_VM < 2) begin : g_bad_vm
      $error("vm_credit_sched: NUM_VM must be at least 2");
   end
   if (SLICE_TICKS < 1) begin : g_bad_slice
      $error("vm_credit_sched: SLICE_TICKS must be at least 1");
   end
   if (TICK_COST < 1 || TICK_COST >= (1 << (CRED_W - 2))) begin : g_bad_cost
      $error("vm_credit_sched: TICK_COST out of range for CRED_W");
   end

   logic [NUM_VM-1:0] queued_q, boost_q, queued_d, boost_d;
   logic [NUM_VM-1:0] under, cur_oh, wake, enq, cand, win_oh;
   vm_class_e [NUM_VM-1:0] cls;
   logic [IDX_W-1:0]  cur_q, win_idx;
   logic              cur_valid_q, preempt_q;
   logic [SLC_W-1:0]  slice_q;
   logic cur_blocked, cur_boost, slice_end, boost_wait;
   logic preempt_now, switch_out, requeue, pick_en, any_cand;

   for (genvar g = 0; g < NUM_VM; g++) begin : g_vm
      assign cur_oh[g] = cur_valid_q && (cur_q == IDX_W'(g));
      assign wake[g]   = !queued_q[g] && !cur_oh[g] && runnable_i[g];
      assign enq[g]    = wake[g] || (requeue && cur_oh[g]);
      assign cand[g]   = queued_q[g] && runnable_i[g];
      assign cls[g]    = boost_q[g] ? CLS_BOOST : (under[g] ? CLS_UNDER : CLS_OVER);
   end

   assign cur_blocked = cur_valid_q && !(|(cur_oh & runnable_i));
   assign cur_boost   = |(cur_oh & boost_q);
   assign slice_end   = cur_valid_q && tick_i && (slice_q == SLC_LAST);
   assign boost_wait  = |(cand & boost_q);
   assign preempt_now = cur_valid_q && !cur_blocked && !cur_boost && boost_wait
                        && !yield_i && !slice_end;
   assign switch_out  = cur_valid_q && (cur_blocked || yield_i || slice_end || preempt_now);
   assign requeue     = switch_out && !cur_blocked;
   assign pick_en     = !cur_valid_q && any_cand;

   vcs_credit_bank #(
      .NUM_VM(NUM_VM), .CRED_W(CRED_W), .TICK_COST(TICK_COST), .IDX_W(IDX_W)
   ) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .allot_i     (allot_i),
      .debit_en_i  (tick_i && cur_valid_q),
      .debit_idx_i (cur_q),
      .under_o     (under)
   );

   vcs_age_pick #(
      .NUM_VM(NUM_VM), .IDX_W(IDX_W)
   ) u_pick (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .enq_i     (enq),
      .cand_i    (cand),
      .cls_i     (cls),
      .win_oh_o  (win_oh),
      .win_idx_o (win_idx),
      .any_o     (any_cand)
   );

   always_comb begin
      queued_d = queued_q;
      boost_d  = boost_q;
      for (int i = 0; i < NUM_VM; i++) begin
         if (enq[i])                              queued_d[i] = 1'b1;
         else if (queued_q[i] && !runnable_i[i])  queued_d[i] = 1'b0;
         else if (pick_en && win_oh[i])           queued_d[i] = 1'b0;

         if (wake[i])                             boost_d[i] = io_evt_i[i];
         else if (cur_oh[i] && switch_out)        boost_d[i] = 1'b0;
         else if (queued_q[i] && !runnable_i[i])  boost_d[i] = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         queued_q    <= '0;
         boost_q     <= '0;
         cur_q       <= '0;
         cur_valid_q <= 1'b0;
         slice_q     <= '0;
         preempt_q   <= 1'b0;
      end else begin
         queued_q  <= queued_d;
         boost_q   <= boost_d;
         preempt_q <= preempt_now;
         if (pick_en) begin
            cur_q       <= win_idx;
            cur_valid_q <= 1'b1;
            slice_q     <= '0;
         end else if (switch_out) begin
            cur_valid_q <= 1'b0;
         end else if (tick_i && cur_valid_q) begin
            slice_q <= slice_q + 1'b1;
         end
      end
   end

   assign run_vm_o    = cur_q;
   assign run_valid_o = cur_valid_q;
   assign preempt_o   = preempt_q;
endmodule

// File: rtl/vcs_checker.sv
module vcs_checker #(
   parameter int NUM_VM = 4,
   parameter int IDX_W  = 2
)(
   input logic              clk_i,
   input logic              rst_ni,
   input logic [NUM_VM-1:0] runnable_i,
   input logic              yield_i,
   input logic [IDX_W-1:0]  run_vm_o,
   input logic              run_valid_o,
   input logic              preempt_o,
   input logic [NUM_VM-1:0] queued_i
);
   AST_PREEMPT_IN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      preempt_o |-> !run_valid_o);                                            // R9
   AST_PREEMPT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      preempt_o |=> !preempt_o);                                              // R9
   AST_NONE_RUNNABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (runnable_i == '0 && !run_valid_o) |=> !run_valid_o);                   // R11
   AST_BLOCKED_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_valid_o && !runnable_i[run_vm_o]) |=> !run_valid_o);               // R10
   AST_YIELD_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_valid_o && yield_i) |=> !run_valid_o);                             // R6
   AST_WAITING_PICKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_valid_o && (queued_i & runnable_i) != '0) |=> run_valid_o);       // R5
   AST_RUNNER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_valid_o && $past(run_valid_o)) |-> $stable(run_vm_o));             // R5
endmodule

bind vm_credit_sched vcs_checker #(.NUM_VM(NUM_VM), .IDX_W(IDX_W)) u_vcs_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .runnable_i  (runnable_i),
   .yield_i     (yield_i),
   .run_vm_o    (run_vm_o),
   .run_valid_o (run_valid_o),
   .preempt_o   (preempt_o),
   .queued_i    (queued_q)
);

// File: tb/vm_credit_sched_tb_top.sv
module vm_credit_sched_tb_top;
   localparam int N = 4, CW = 16, COST = 10, SL = 3, IW = 2;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, yld = 1'b0;
   logic [N-1:0] run = '0, io = '0;
   logic [N*CW-1:0] allot = '0;
   logic [IW-1:0] vm_o;
   logic vld_o, pre_o;

   always #5 clk = ~clk;

   vm_credit_sched #(.NUM_VM(N), .CRED_W(CW), .TICK_COST(COST), .SLICE_TICKS(SL)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .runnable_i(run), .io_evt_i(io),
      .yield_i(yld), .allot_i(allot), .run_vm_o(vm_o), .run_valid_o(vld_o), .preempt_o(pre_o)
   );

   int n_chk = 0, n_fail = 0, n_pre = 0;
   string tag = "R1";

   // behavioural reference state
   int m_cr[N]; bit m_q[N]; bit m_bs[N]; int m_st[N];
   int m_stamp; bit m_vld; int m_cur; int m_slc; bit m_primed; bit m_pre;
   int al[N]; int al_next[N];

   task automatic check(string req, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare();
      check(tag, int'(vld_o), int'(m_vld), "run_valid");
      check(tag, int'(pre_o), int'(m_pre), "preempt");
      if (m_vld) check(tag, int'(vm_o), m_cur, "run_vm");
      if (m_pre) n_pre++;
   endtask

   function automatic void model_reset();
      for (int i = 0; i < N; i++) begin
         m_cr[i] = 0; m_q[i] = 0; m_bs[i] = 0; m_st[i] = 0;
      end
      m_stamp = 0; m_vld = 0; m_cur = 0; m_slc = 0; m_primed = 0; m_pre = 0;
   endfunction

   function automatic void model_step();
      bit blocked, send, pnow, sw, rq, bw;
      bit cand[N];
      int best, win, sum;
      blocked = m_vld && !run[m_cur];
      send    = m_vld && tick && (m_slc == SL - 1);
      bw = 0;
      for (int i = 0; i < N; i++) begin
         cand[i] = m_q[i] && run[i];
         if (cand[i] && m_bs[i]) bw = 1;
      end
      pnow = m_vld && !blocked && !m_bs[m_cur] && bw && !yld && !send;
      sw   = m_vld && (blocked || yld || send || pnow);
      rq   = sw && !blocked;
      win = -1; best = -1;
      if (!m_vld) begin
         for (int i = 0; i < N; i++) begin
            if (cand[i]) begin
               int c;
               c = m_bs[i] ? 2 : (m_cr[i] > 0 ? 1 : 0);
               if (win < 0 || c > best || (c == best && m_st[i] < m_st[win])) begin
                  best = c; win = i;
               end
            end
         end
      end
      sum = 0;
      for (int i = 0; i < N; i++) sum += m_cr[i];
      if (!m_primed || sum < 0) begin
         for (int i = 0; i < N; i++) m_cr[i] = al[i];
         m_primed = 1;
      end else if (tick && m_vld) begin
         m_cr[m_cur] -= COST;
      end
      for (int i = 0; i < N; i++) begin
         bit idle, wk, dq, en;
         idle = !m_q[i] && !(m_vld && m_cur == i);
         wk   = idle && run[i];
         dq   = m_q[i] && !run[i];
         en   = wk || (rq && m_cur == i);
         if (wk) m_bs[i] = io[i];
         else if (sw && m_cur == i) m_bs[i] = 0;
         else if (dq) m_bs[i] = 0;
         if (en) begin m_q[i] = 1; m_st[i] = m_stamp; m_stamp++; end
         else if (dq) m_q[i] = 0;
         else if (win == i) m_q[i] = 0;
      end
      m_pre = pnow;
      if (win >= 0) begin m_cur = win; m_vld = 1; m_slc = 0; end
      else if (sw) m_vld = 0;
      else if (tick && m_vld) m_slc++;
   endfunction

   task automatic set_allot(int a0, int a1, int a2, int a3);
      al_next[0] = a0; al_next[1] = a1; al_next[2] = a2; al_next[3] = a3;
   endtask

   task automatic cyc(logic [N-1:0] r, logic [N-1:0] e, logic y, logic t);
      @(negedge clk);
      compare();
      run = r; io = e; yld = y; tick = t;
      for (int i = 0; i < N; i++) begin
         al[i] = al_next[i];
         allot[i*CW +: CW] = al[i][CW-1:0];
      end
      model_step();
   endtask

   function automatic logic [N-1:0] rnd_bits(int k);
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = ($urandom % k) == 0;
      return v;
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      finish_run();
   end

   initial begin
      logic [N-1:0] r;
      void'($urandom(7));
      model_reset();
      set_allot(40, 40, 40, 40);
      for (int i = 0; i < N; i++) begin
         al[i] = al_next[i];
         allot[i*CW +: CW] = al[i][CW-1:0];
      end
      // R1: reset holds outputs low
      repeat (3) @(negedge clk);
      tag = "R1"; compare();
      rst_n = 1'b1;
      model_step();
      cyc('0, '0, 0, 0);

      // R11 and R10: nothing runnable, stray I/O events on idle VMs
      tag = "R11";
      for (int k = 0; k < 30; k++) cyc('0, rnd_bits(2), 0, ($urandom % 2) == 0);
      tag = "R10";
      for (int k = 0; k < 10; k++) cyc('0, 4'hF, 0, 1);

      // R4: all wake together, frequent yields, no ticks: FIFO rotation
      tag = "R4";
      for (int k = 0; k < 80; k++) cyc(4'hF, '0, (k % 4) == 3, 0);

      // R2/R3: steady ticks drain credit, unequal allotments separate classes
      tag = "R2";
      set_allot(10, 40, 70, 20);
      for (int k = 0; k < 150; k++) cyc(4'hF, '0, 0, 1);
      tag = "R3";
      set_allot(0, 30, 5, 60);
      for (int k = 0; k < 150; k++) cyc(4'hF, '0, 0, ($urandom % 2) == 0);

      // R5: sparse ticks, slice boundaries
      tag = "R5";
      set_allot(50, 50, 50, 50);
      for (int k = 0; k < 150; k++) cyc(4'hF, '0, 0, ($urandom % 3) == 0);

      // R6: switch-request heavy
      tag = "R6";
      for (int k = 0; k < 120; k++) cyc(4'hF, '0, ($urandom % 3) == 0, ($urandom % 4) == 0);

      // R7: negative and zero allotments force repeated reloads
      tag = "R7";
      set_allot(-20, 40, 5, 0);
      for (int k = 0; k < 150; k++) cyc(4'hF, '0, ($urandom % 6) == 0, 1);
      set_allot(-30, -10, 5, 0);
      for (int k = 0; k < 40; k++) cyc(4'hF, '0, 0, 1);

      // R9: directed preemption of a non-boosted runner
      tag = "R9";
      set_allot(30, 30, 30, 30);
      for (int k = 0; k < 5; k++) cyc('0, '0, 0, 0);
      for (int k = 0; k < 4; k++) cyc(4'b0001, '0, 0, 0);
      cyc(4'b0101, 4'b0100, 0, 0);
      for (int k = 0; k < 6; k++) cyc(4'b0101, '0, 0, 0);
      check("R9", n_pre > 0, 1, "preempt_seen");
      // boosted runner not displaced by a second boosted wake
      cyc(4'b0111, 4'b0010, 0, 0);
      for (int k = 0; k < 6; k++) cyc(4'b0111, '0, 0, 0);

      // R8: random wakes with I/O events
      tag = "R8";
      r = 4'hF;
      for (int k = 0; k < 400; k++) begin
         for (int i = 0; i < N; i++) if (($urandom % 10) == 0) r[i] = ~r[i];
         cyc(r, rnd_bits(3), ($urandom % 8) == 0, ($urandom % 4) == 0);
      end

      // R10: frequent runnable drops
      tag = "R10";
      for (int k = 0; k < 300; k++) cyc(rnd_bits(2) | 4'b0001 & rnd_bits(2), rnd_bits(4),
                                         ($urandom % 10) == 0, ($urandom % 3) == 0);
      for (int k = 0; k < 5; k++) cyc('0, '0, 0, 0);
      @(negedge clk); compare();
      finish_run();
   end
endmodule